// File: doc/BRIEF.md
# Extended Wait Monitor with Interrupts

This block watches one external wait input per chip-select space of an asynchronous memory port. While the cycle sequencer is in the strobe phase of an access, the block can ask it to hold the strobe longer. It raises that request when the selected space has waiting enabled and its pin is at the waiting level. The waiting level is chosen per pin. A programmable limit bounds how long one strobe phase can be stretched. When the limit runs out, the request is withdrawn for the rest of that phase and a timeout is recorded. The sequencer then finishes the access with whatever data is on the bus.

The block also keeps sticky event flags. There is one flag per wait pin for a rising edge of that pin, and one flag for a timeout. Each flag has a mask bit. The mask bits are set through one register address and cleared through another, and in both cases software writes ones. A registered interrupt output is high while any flag that is not masked off is set. Every wait pin passes through a two-flop synchronizer before the block uses it.

Top module: `ewait_monitor`

## Requirements
- R1: After reset, `extend` and `irq` are 0, and the configuration (address 0), the status (address 1) and the mask (addresses 2 and 3) all read 0. A read returns the addressed register on `reg_rdata` one cycle after `reg_addr` is presented.
- R2: Configuration bit i (bits 3:0) sets the waiting level of pin i: 1 means waiting while the pin is high, 0 means waiting while it is low. `extend` rises 3 cycles after the pin of the selected space reaches its waiting level during a strobe. Those 3 cycles are two synchronizer flops and the output register.
- R3: `extend` stays 0 when `strobe_active` is low, and when the enable bit of the selected space (configuration bits 7:4, bit 4+i for space i) is 0.
- R4: Let L be the limit field (configuration bits 15:8). Within one strobe phase, `extend` stays high for at most (L+1)*16 consecutive cycles. It then drops for the rest of that phase even if the pin keeps waiting. The timeout flag (status bit 4) is readable from the cycle in which `extend` drops. A wait that ends before the limit sets no timeout.
- R5: The wait counter and the timed-out state restart whenever `strobe_active` is low, so a new strobe phase can again stretch for the full limit.
- R6: A rising edge of synchronized pin i sets status bit i. This happens whether or not a strobe is active or the space is enabled. Status bits stay set until they are cleared.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: Writing ones to address 2 sets the matching mask bits, and writing ones to address 3 clears them. Zeros written to either address have no effect. Both addresses read back the current mask, whose layout is the same as the status register.
- R9: `irq` is the OR of status bits ANDed with their mask bits, registered, so it follows a mask or status change by one cycle.
- R10: `extend` falls 3 cycles after the pin leaves its waiting level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_pin | input | NUM_SPACES | Asynchronous wait inputs, one per space |
| strobe_active | input | 1 | Sequencer is in the strobe phase |
| strobe_cs | input | CS_W | Space index of the current access |
| extend | output | 1 | Request to stretch the strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the limit boundary at two field values (16 and 32 cycles). A counter that is off by one would keep `extend` high one cycle too long or drop it one cycle early, and the timeout flag would appear in the wrong cycle. The bench also lets a timed-out strobe end and starts a new one while the pin is still waiting. A counter that did not restart would never stretch again. Both waiting levels are exercised, along with a disabled space and a pin that waits outside any strobe. A design that ignored polarity or enable would raise `extend` in the wrong place. The bench writes zeros to the clear and mask registers, and a mask that ignored them would wrongly lose bits or let `irq` through.

// File: rtl/ewm_pkg.sv
package ewm_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_MSET = 2'd2;
  localparam logic [1:0] ADDR_MCLR = 2'd3;
  localparam int unsigned GRANULE_SHIFT = 4;
endpackage

// File: rtl/ewm_sync.sv
module ewm_sync #(
  parameter int unsigned NUM_SPACES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SPACES-1:0] pin_i,
  output logic [NUM_SPACES-1:0] lvl_o,
  output logic [NUM_SPACES-1:0] rise_o
);
  logic [NUM_SPACES-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= pin_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign rise_o[g] = sync_q[g] & ~prev_q[g];
  end

  assign lvl_o = sync_q;
endmodule

// File: rtl/ewm_stretch.sv
module ewm_stretch #(
  parameter int unsigned NUM_SPACES = 4,
  parameter int unsigned CS_W       = 2,
  parameter int unsigned LIMIT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe_active,
  input  logic [CS_W-1:0]       strobe_cs,
  input  logic [NUM_SPACES-1:0] lvl_i,
  input  logic [NUM_SPACES-1:0] pol_i,
  input  logic [NUM_SPACES-1:0] en_i,
  input  logic [LIMIT_W-1:0]    limit_i,
  output logic                  extend_o,
  output logic                  tmo_o
);
  localparam int unsigned CNT_W = LIMIT_W + 1 + ewm_pkg::GRANULE_SHIFT;

  logic [LIMIT_W:0]  lim_p1;
  logic [CNT_W-1:0]  max_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, ext_q;
  logic              at_level, waiting, at_max;

  assign lim_p1   = {1'b0, limit_i} + {{LIMIT_W{1'b0}}, 1'b1};
  assign max_w    = {lim_p1, {ewm_pkg::GRANULE_SHIFT{1'b0}}};
  assign at_level = (lvl_i[strobe_cs] == pol_i[strobe_cs]);
  assign waiting  = strobe_active && en_i[strobe_cs] && at_level && !done_q;
  assign at_max   = (cnt_q >= max_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (!strobe_active) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (waiting) begin
      if (at_max) begin
        done_q <= 1'b1;
        ext_q  <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        ext_q  <= 1'b1;
      end
    end else begin
      ext_q <= 1'b0;
    end
  end

  assign extend_o = ext_q;
  assign tmo_o    = waiting && at_max;

  // R3: a stretch request only follows a cycle with an active strobe
  p_ext_needs_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    ext_q |-> $past(strobe_active));
  // R2: a stretch request only follows the selected pin at its waiting level
  p_ext_needs_level_r2: assert property (@(posedge clk) disable iff (rst)
    ext_q |-> $past(lvl_i[strobe_cs] == pol_i[strobe_cs]));
  // R4: a timeout withdraws the request on the next edge
  p_tmo_drops_ext_r4: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> !ext_q);
  // R5: a strobe-free cycle restarts the count
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe_active |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/ewm_regs.sv
module ewm_regs #(
  parameter int unsigned NUM_SPACES = 4,
  parameter int unsigned LIMIT_W    = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_SPACES-1:0] rise_i,
  input  logic                  tmo_i,
  output logic [NUM_SPACES-1:0] pol_o,
  output logic [NUM_SPACES-1:0] en_o,
  output logic [LIMIT_W-1:0]    limit_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  import ewm_pkg::*;

  localparam int unsigned CFG_W = 2 * NUM_SPACES + LIMIT_W;
  localparam int unsigned ST_W  = NUM_SPACES + 1;

  logic [NUM_SPACES-1:0] pol_q, en_q;
  logic [LIMIT_W-1:0]    lim_q;
  logic [ST_W-1:0]       status_q, status_n, mask_q, mask_n, events;
  logic [DATA_W-1:0]     rdata_q, rdata_n;
  logic                  irq_q;
  logic                  wr_cfg, wr_stat, wr_mset, wr_mclr;

  assign wr_cfg  = we_i && (addr_i == ADDR_CFG);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign wr_mset = we_i && (addr_i == ADDR_MSET);
  assign wr_mclr = we_i && (addr_i == ADDR_MCLR);
  assign events  = {tmo_i, rise_i};

  always_comb begin
    status_n = status_q;
    if (wr_stat) status_n = status_n & ~wdata_i[ST_W-1:0];
    status_n = status_n | events;
  end

  always_comb begin
    mask_n = mask_q;
    if (wr_mset) mask_n = mask_n | wdata_i[ST_W-1:0];
    if (wr_mclr) mask_n = mask_n & ~wdata_i[ST_W-1:0];
  end

  always_comb begin
    rdata_n = '0;
    case (addr_i)
      ADDR_CFG:  rdata_n[CFG_W-1:0] = {lim_q, en_q, pol_q};
      ADDR_STAT: rdata_n[ST_W-1:0]  = status_q;
      default:   rdata_n[ST_W-1:0]  = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q    <= '0;
      en_q     <= '0;
      lim_q    <= '0;
      status_q <= '0;
      mask_q   <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_cfg) {lim_q, en_q, pol_q} <= wdata_i[CFG_W-1:0];
      status_q <= status_n;
      mask_q   <= mask_n;
      rdata_q  <= rdata_n;
      irq_q    <= |(status_q & mask_q);
    end
  end

  assign pol_o   = pol_q;
  assign en_o    = en_q;
  assign limit_o = lim_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R6: flags are sticky unless a clear write is made
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> (($past(status_q) & ~status_q) == '0));
  // R6: every edge event is recorded on the next edge
  p_rise_recorded_r6: assert property (@(posedge clk) disable iff (rst)
    (|rise_i) |=> ((status_q[NUM_SPACES-1:0] & $past(rise_i)) == $past(rise_i)));
  // R8: a clear write removes the written mask bits
  p_mask_clr_r8: assert property (@(posedge clk) disable iff (rst)
    wr_mclr |=> ((mask_q & $past(wdata_i[ST_W-1:0])) == '0));
  // R9: no interrupt without some enabled mask bit one cycle earlier
  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(mask_q != '0));
endmodule

// File: rtl/ewait_monitor.sv
module ewait_monitor #(
  parameter int unsigned NUM_SPACES = 4,
  parameter int unsigned LIMIT_W    = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CS_W       = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SPACES-1:0] wait_pin,
  input  logic                  strobe_active,
  input  logic [CS_W-1:0]       strobe_cs,
  output logic                  extend,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq
);
  logic [NUM_SPACES-1:0] lvl, rise, pol, en;
  logic [LIMIT_W-1:0]    limit;
  logic                  tmo;

  ewm_sync #(.NUM_SPACES(NUM_SPACES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(wait_pin), .lvl_o(lvl), .rise_o(rise)
  );

  ewm_stretch #(.NUM_SPACES(NUM_SPACES), .CS_W(CS_W), .LIMIT_W(LIMIT_W)) u_stretch (
    .clk(clk), .rst(rst), .strobe_active(strobe_active), .strobe_cs(strobe_cs),
    .lvl_i(lvl), .pol_i(pol), .en_i(en), .limit_i(limit),
    .extend_o(extend), .tmo_o(tmo)
  );

  ewm_regs #(.NUM_SPACES(NUM_SPACES), .LIMIT_W(LIMIT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .rise_i(rise), .tmo_i(tmo), .pol_o(pol), .en_o(en), .limit_o(limit),
    .rdata_o(reg_rdata), .irq_o(irq)
  );

  // R1: outputs are quiet in the cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !extend && !irq);
endmodule

// File: tb/ewait_monitor_test.sv
`timescale 1ns/1ps
module ewait_monitor_test;
  localparam int SEL_RD = 0, SEL_EXT = 1, SEL_IRQ = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wait_pin = 4'b0000;
  logic        strobe_active = 1'b0;
  logic [1:0]  strobe_cs = 2'd0;
  logic        extend;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [31:0] act;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  ewait_monitor uut (
    .clk(clk), .rst(rst), .wait_pin(wait_pin), .strobe_active(strobe_active),
    .strobe_cs(strobe_cs), .extend(extend), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every expected item whose cycle has come
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        case (q[i].sel)
          SEL_RD:  act = reg_rdata;
          SEL_EXT: act = {31'd0, extend};
          default: act = {31'd0, irq};
        endcase
        checks++;
        if (q[i].due != cyc || act !== q[i].exp) begin
          fails++;
          $display("FAIL %s cycle %0d sel %0d: actual %h expected %h",
                   q[i].req, cyc, q[i].sel, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int due, input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    push(cyc + 1, SEL_RD, exp, req);
    tick(1);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int c;
    tick(5);
    rst = 1'b0;
    // R1 reset state
    push(cyc + 1, SEL_EXT, 0, "R1");
    push(cyc + 1, SEL_IRQ, 0, "R1");
    rd(2'd0, 32'h0, "R1");
    rd(2'd1, 32'h0, "R1");
    rd(2'd2, 32'h0, "R1");
    rd(2'd3, 32'h0, "R1");

    // R6 rising edges on pins 1..3, R7 write-one-to-clear
    wait_pin = 4'b1110;
    tick(5);
    rd(2'd1, 32'h0E, "R6");
    wr(2'd1, 32'h04);
    rd(2'd1, 32'h0A, "R7");
    wr(2'd1, 32'h00);
    rd(2'd1, 32'h0A, "R7");
    wr(2'd1, 32'h0A);
    rd(2'd1, 32'h00, "R7");

    // pol: space0 high, others low; enable spaces 0,1; limit 0
    wr(2'd0, 32'h31);
    rd(2'd0, 32'h31, "R1");

    // R2 active-high wait, R4 16-cycle limit
    c = cyc;
    strobe_active = 1'b1; strobe_cs = 2'd0; wait_pin[0] = 1'b1;
    push(c + 2,  SEL_EXT, 0, "R2");
    push(c + 3,  SEL_EXT, 1, "R2");
    push(c + 18, SEL_EXT, 1, "R4");
    push(c + 19, SEL_EXT, 0, "R4");
    push(c + 21, SEL_EXT, 0, "R4");
    tick(21);
    // R5 restart on a new strobe phase
    strobe_active = 1'b0;
    tick(1);
    strobe_active = 1'b1;
    push(c + 23, SEL_EXT, 1, "R5");
    push(c + 38, SEL_EXT, 1, "R5");
    push(c + 39, SEL_EXT, 0, "R4");
    tick(19);
    strobe_active = 1'b0;
    tick(1);
    rd(2'd1, 32'h11, "R4");
    push(cyc + 1, SEL_IRQ, 0, "R9");
    tick(1);

    // R8/R9 mask set and clear
    wr(2'd2, 32'h10);
    push(cyc + 1, SEL_IRQ, 1, "R9");
    tick(1);
    rd(2'd3, 32'h10, "R8");
    wr(2'd3, 32'h00);
    rd(2'd2, 32'h10, "R8");
    wr(2'd2, 32'h00);
    rd(2'd2, 32'h10, "R8");
    wr(2'd3, 32'h10);
    push(cyc + 1, SEL_IRQ, 0, "R8");
    tick(1);
    wr(2'd1, 32'h11);
    rd(2'd1, 32'h00, "R7");

    // R3 disabled space 2 with its pin waiting
    c = cyc;
    strobe_active = 1'b1; strobe_cs = 2'd2; wait_pin[2] = 1'b0;
    push(c + 3, SEL_EXT, 0, "R3");
    push(c + 5, SEL_EXT, 0, "R3");
    push(c + 8, SEL_EXT, 0, "R3");
    tick(9);
    // R3 enabled space 1 waiting with no strobe
    strobe_active = 1'b0; wait_pin[2] = 1'b1; wait_pin[1] = 1'b0;
    push(cyc + 4, SEL_EXT, 0, "R3");
    tick(5);
    wait_pin[1] = 1'b1;
    tick(5);

    // R2 active-low wait, R10 release
    c = cyc;
    strobe_active = 1'b1; strobe_cs = 2'd1; wait_pin[1] = 1'b0;
    push(c + 2, SEL_EXT, 0, "R2");
    push(c + 3, SEL_EXT, 1, "R2");
    push(c + 7, SEL_EXT, 1, "R10");
    push(c + 8, SEL_EXT, 0, "R10");
    tick(5);
    wait_pin[1] = 1'b1;
    tick(5);
    strobe_active = 1'b0;
    rd(2'd1, 32'h06, "R4");
    wr(2'd2, 32'h02);
    push(cyc + 1, SEL_IRQ, 1, "R9");
    tick(1);
    wr(2'd3, 32'h02);
    wr(2'd1, 32'h06);
    rd(2'd1, 32'h00, "R7");

    // R4 limit field 1 -> 32 cycles
    wr(2'd0, 32'h131);
    wait_pin[0] = 1'b0;
    tick(4);
    c = cyc;
    strobe_active = 1'b1; strobe_cs = 2'd0; wait_pin[0] = 1'b1;
    push(c + 2,  SEL_EXT, 0, "R4");
    push(c + 3,  SEL_EXT, 1, "R4");
    push(c + 34, SEL_EXT, 1, "R4");
    push(c + 35, SEL_EXT, 0, "R4");
    tick(37);
    strobe_active = 1'b0;
    rd(2'd1, 32'h11, "R4");
    tick(3);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL pending: actual %0d items expected 0", q.size());
    end
    report();
  end
endmodule